// File: doc/BRIEF.md
# Row-Buffered Single-Bit Memory Array

This block models a one-bit-wide dynamic memory of 2048 rows by 2048 columns. The address arrives over a narrow shared bus in two steps: first a row number, qualified by a row strobe, then one or more column numbers, each qualified by a column strobe. Opening a row copies all 2048 bits of that row out of the cell array into a static row buffer. Every column access after that, whether a read or a write, is served from the buffer and not from the array.

A precharge strobe closes the open row and writes the buffer back into the array. If a row strobe arrives while a row is still open, the block first spills the old row back and then fetches the new one. This costs one more busy cycle than opening a row from the closed state. A column strobe while no row is open is a protocol error: the block raises a one-cycle error flag and drives 0 on the data output.

The cell array is a plain synchronous memory with one read port and one write port, so it can map onto block RAM. The row buffer is a register stage beside it.

Top module: `rowbuf_dram`

## Requirements
- R1: While reset is high and in the cycle after it, the block reports no open row, `busy` low, `err` low and `rd_bit` 0. All cells start at 0.
- R2: A row strobe with no row open and `busy` low drives `busy` high for exactly one cycle. After that cycle `row_open` is high and the buffer holds that row's stored bits.
- R3: A row strobe while a row is open first writes the buffer back to the old row and then loads the new row. `busy` stays high for exactly two cycles before `row_open` returns high.
- R4: A column strobe with `wr_en` 0 on an open row places bit `addr` of the row buffer on `rd_bit` in the cycle after the strobe, with `err` low.
- R5: A column strobe with `wr_en` 1 on an open row sets bit `addr` of the row buffer to `wr_bit`. Later reads of that column in the same open row return the new value.
- R6: A precharge strobe on an open row writes the buffer back to the array and closes the row (`row_open` low, `busy` low, the next cycle). Reopening the row later returns the written data. A precharge strobe with no row open has no effect.
- R7: A column strobe with no row open raises `err` for one cycle, forces `rd_bit` to 0, and changes no stored bit.
- R8: Every strobe that arrives while `busy` is high is ignored. It raises no error and changes no stored bit.
- R9: When strobes coincide, the row strobe wins over precharge, and precharge wins over the column strobe. The losing strobes in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 11 | Shared address bus: row number with `row_stb`, column number with `col_stb` |
| row_stb | input | 1 | Open the row given on `addr` |
| col_stb | input | 1 | Column access at `addr` within the open row |
| pre_stb | input | 1 | Write back and close the open row |
| wr_en | input | 1 | With `col_stb`: 1 writes `wr_bit`, 0 reads |
| wr_bit | input | 1 | Data bit to write |
| rd_bit | output | 1 | Registered read data, 0 after a protocol error |
| err | output | 1 | One-cycle flag for a column strobe with no row open |
| busy | output | 1 | High while a row is being fetched or spilled |
| row_open | output | 1 | High while a row sits in the buffer and accepts column strobes |

## Verification
The bench targets three corner cases.

The first is writing a column, then closing and reopening the same row, and also switching straight to another row and back. A design that skipped the write-back, or read the new row before the spill landed, would return stale zeros.

The second is strobes during the busy window and strobes that coincide. A design that let them through would corrupt the fetched buffer or raise false errors.

The third is column strobes with no row open. A design that got this wrong would leave stale data on `rd_bit` or write into a buffer that is not open.

The busy length is counted on every row open, so a missing or extra spill cycle is caught.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
  typedef enum logic [1:0] {
    ST_CLOSED = 2'd0,
    ST_FETCH  = 2'd1,
    ST_SPILL  = 2'd2,
    ST_ACTIVE = 2'd3
  } bank_state_t;
endpackage

// File: rtl/rowbuf_cell_array.sv
module rowbuf_cell_array #(
  parameter int ROW_AW  = 11,
  parameter int ROW_LEN = 2048
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ROW_AW-1:0]  wr_row,
  input  logic [ROW_LEN-1:0] wr_data,
  input  logic               rd_en,
  input  logic [ROW_AW-1:0]  rd_row,
  output logic [ROW_LEN-1:0] rd_data
);
  localparam int DEPTH = 1 << ROW_AW;

  logic [ROW_LEN-1:0] cells [DEPTH];

  // power-up content of the block RAM: all zero
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_row] <= wr_data;
    if (rd_en) rd_data <= cells[rd_row];
  end
endmodule

// File: rtl/rowbuf_line.sv
module rowbuf_line #(
  parameter int COL_AW = 11,
  localparam int ROW_LEN = 1 << COL_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [ROW_LEN-1:0] load_data,
  input  logic               col_rd,
  input  logic               col_wr,
  input  logic [COL_AW-1:0]  col,
  input  logic               wbit,
  input  logic               clr_q,
  output logic [ROW_LEN-1:0] line_q,
  output logic               bit_q
);
  always_ff @(posedge clk) begin
    if (load_en) line_q <= load_data;
    else if (col_wr) line_q[col] <= wbit;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_q) bit_q <= 1'b0;
    else if (col_rd) bit_q <= line_q[col];
  end
endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
  import rowbuf_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_stb,
  input  logic          col_stb,
  input  logic          pre_stb,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output bank_state_t   st,
  output logic [AW-1:0] cur_row,
  output logic          arr_we,
  output logic          arr_re,
  output logic [AW-1:0] arr_raddr,
  output logic          buf_load,
  output logic          col_rd,
  output logic          col_wr,
  output logic          clr_q,
  output logic          err_q
);
  bank_state_t   nxt;
  logic [AW-1:0] nxt_row;
  logic          nxt_err;

  always_comb begin
    nxt       = st;
    nxt_row   = cur_row;
    nxt_err   = 1'b0;
    arr_we    = 1'b0;
    arr_re    = 1'b0;
    arr_raddr = addr;
    buf_load  = 1'b0;
    col_rd    = 1'b0;
    col_wr    = 1'b0;
    clr_q     = 1'b0;
    unique case (st)
      ST_CLOSED: begin
        if (row_stb) begin
          arr_re  = 1'b1;
          nxt_row = addr;
          nxt     = ST_FETCH;
        end else if (!pre_stb && col_stb) begin
          nxt_err = 1'b1;
          clr_q   = 1'b1;
        end
      end
      ST_FETCH: begin
        buf_load = 1'b1;
        nxt      = ST_ACTIVE;
      end
      ST_SPILL: begin
        arr_re    = 1'b1;
        arr_raddr = cur_row;
        nxt       = ST_FETCH;
      end
      ST_ACTIVE: begin
        if (row_stb) begin
          arr_we  = 1'b1;
          nxt_row = addr;
          nxt     = ST_SPILL;
        end else if (pre_stb) begin
          arr_we = 1'b1;
          nxt    = ST_CLOSED;
        end else if (col_stb) begin
          col_rd = !wr_en;
          col_wr = wr_en;
        end
      end
      default: nxt = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_CLOSED;
      cur_row <= '0;
      err_q   <= 1'b0;
    end else begin
      st      <= nxt;
      cur_row <= nxt_row;
      err_q   <= nxt_err;
    end
  end
endmodule

// File: rtl/rowbuf_dram.sv
module rowbuf_dram
  import rowbuf_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          row_stb,
  input  logic          col_stb,
  input  logic          pre_stb,
  input  logic          wr_en,
  input  logic          wr_bit,
  output logic          rd_bit,
  output logic          err,
  output logic          busy,
  output logic          row_open
);
  localparam int ROW_LEN = 1 << AW;

  bank_state_t        st;
  logic [AW-1:0]      cur_row;
  logic [AW-1:0]      arr_raddr;
  logic               arr_we, arr_re;
  logic               buf_load, col_rd, col_wr, clr_q;
  logic [ROW_LEN-1:0] arr_rdata;
  logic [ROW_LEN-1:0] line_q;

  rowbuf_ctrl #(.AW(AW)) i_ctrl (
    .clk(clk), .rst(rst), .row_stb(row_stb), .col_stb(col_stb),
    .pre_stb(pre_stb), .wr_en(wr_en), .addr(addr), .st(st),
    .cur_row(cur_row), .arr_we(arr_we), .arr_re(arr_re),
    .arr_raddr(arr_raddr), .buf_load(buf_load), .col_rd(col_rd),
    .col_wr(col_wr), .clr_q(clr_q), .err_q(err)
  );

  rowbuf_cell_array #(.ROW_AW(AW), .ROW_LEN(ROW_LEN)) i_array (
    .clk(clk), .wr_en(arr_we), .wr_row(cur_row), .wr_data(line_q),
    .rd_en(arr_re), .rd_row(arr_raddr), .rd_data(arr_rdata)
  );

  rowbuf_line #(.COL_AW(AW)) i_line (
    .clk(clk), .rst(rst), .load_en(buf_load), .load_data(arr_rdata),
    .col_rd(col_rd), .col_wr(col_wr), .col(addr), .wbit(wr_bit),
    .clr_q(clr_q), .line_q(line_q), .bit_q(rd_bit)
  );

  assign busy     = (st == ST_FETCH) || (st == ST_SPILL);
  assign row_open = (st == ST_ACTIVE);
endmodule

// File: rtl/rowbuf_dram_checker.sv
module rowbuf_dram_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          row_stb,
  input logic          col_stb,
  input logic          pre_stb,
  input logic          wr_en,
  input logic          wr_bit,
  input logic          rd_bit,
  input logic          err,
  input logic          busy,
  input logic          row_open
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!row_open && !busy && !err && !rd_bit));

  // R2
  open_from_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (row_stb && !busy && !row_open) |=> busy ##1 (!busy && row_open));

  // R3
  reopen_spill_chk: assert property (@(posedge clk) disable iff (rst)
    (row_stb && row_open) |=> busy ##1 busy ##1 (!busy && row_open));

  // R6
  precharge_close_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_stb && !row_stb && row_open) |=> (!row_open && !busy));

  // R7
  closed_column_err_chk: assert property (@(posedge clk) disable iff (rst)
    (col_stb && !row_stb && !pre_stb && !busy && !row_open) |=> (err && !rd_bit));

  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(col_stb) && !$past(busy) && !$past(row_open)));

  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && row_open));
endmodule

bind rowbuf_dram rowbuf_dram_checker #(.AW(AW)) i_rowbuf_chk (
  .clk(clk), .rst(rst), .addr(addr), .row_stb(row_stb), .col_stb(col_stb),
  .pre_stb(pre_stb), .wr_en(wr_en), .wr_bit(wr_bit), .rd_bit(rd_bit),
  .err(err), .busy(busy), .row_open(row_open)
);

// File: tb/test_rowbuf_dram.sv
module test_rowbuf_dram;
  localparam int AW = 11;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          row_stb = 1'b0, col_stb = 1'b0, pre_stb = 1'b0;
  logic          wr_en = 1'b0, wr_bit = 1'b0;
  logic          rd_bit, err, busy, row_open;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0]  mdl [N];
  logic [N-1:0]  mbuf;
  logic [AW-1:0] mrow;
  bit            mopen;

  always #4 clk = ~clk;

  rowbuf_dram #(.AW(AW)) i_rowbuf_dram (
    .clk(clk), .rst(rst), .addr(addr), .row_stb(row_stb), .col_stb(col_stb),
    .pre_stb(pre_stb), .wr_en(wr_en), .wr_bit(wr_bit), .rd_bit(rd_bit),
    .err(err), .busy(busy), .row_open(row_open)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    row_stb = 0; col_stb = 0; pre_stb = 0; wr_en = 0; wr_bit = 0;
  endtask

  task automatic open_row(input logic [AW-1:0] r);
    bit was = mopen;
    @(negedge clk); clear_in(); addr = r; row_stb = 1;
    @(negedge clk); clear_in();
    check(was ? "R3 busy first" : "R2 busy", busy, 1);
    if (was) begin
      @(negedge clk);
      check("R3 busy second", busy, 1);
      mdl[mrow] = mbuf;
    end
    @(negedge clk);
    check(was ? "R3 busy end" : "R2 busy end", busy, 0);
    check(was ? "R3 open" : "R2 open", row_open, 1);
    mbuf = mdl[r]; mrow = r; mopen = 1;
  endtask

  task automatic precharge();
    @(negedge clk); clear_in(); pre_stb = 1;
    @(negedge clk); clear_in();
    check("R6 closed", row_open, 0);
    check("R6 not busy", busy, 0);
    if (mopen) mdl[mrow] = mbuf;
    mopen = 0;
  endtask

  task automatic col_access(input logic [AW-1:0] c, input bit w, input bit d);
    @(negedge clk); clear_in(); addr = c; col_stb = 1; wr_en = w; wr_bit = d;
    @(negedge clk); clear_in();
    if (!mopen) begin
      check("R7 err", err, 1);
      check("R7 rd zero", rd_bit, 0);
    end else begin
      check(w ? "R5 no err" : "R4 no err", err, 0);
      if (w) mbuf[c] = d;
      else check("R4 read", rd_bit, mbuf[c]);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    for (int i = 0; i < N; i++) mdl[i] = '0;
    mopen = 0; mbuf = '0; mrow = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 row_open", row_open, 0);
    check("R1 busy", busy, 0);
    check("R1 err", err, 0);
    check("R1 rd_bit", rd_bit, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after release", {row_open, busy, err}, 0);

    // R7: column access on a closed bank, write must not land
    col_access(11'd5, 1'b0, 1'b0);
    col_access(11'd5, 1'b1, 1'b1);
    @(negedge clk);
    check("R7 err one cycle", err, 0);
    open_row(11'd3);
    col_access(11'd5, 1'b0, 1'b0);

    // R5: write into buffer at both column ends and read back
    col_access(11'd0, 1'b1, 1'b1);
    col_access(N - 1, 1'b1, 1'b1);
    col_access(11'd0, 1'b0, 1'b0);
    col_access(N - 1, 1'b0, 1'b0);

    // R6: close, precharge again on closed bank, reopen
    precharge();
    precharge();
    check("R6 idle precharge err", err, 0);
    open_row(11'd3);
    col_access(11'd0, 1'b0, 1'b0);
    check("R6 written back", rd_bit, 1);

    // R3: switch rows directly, then come back
    col_access(11'd7, 1'b1, 1'b1);
    open_row(N - 1);
    col_access(11'd7, 1'b0, 1'b0);
    open_row(11'd3);
    col_access(11'd7, 1'b0, 1'b0);
    check("R3 spilled bit", rd_bit, 1);

    // R8: column write held during both busy cycles of a switch
    @(negedge clk); clear_in(); addr = 11'd9; row_stb = 1;
    @(negedge clk); clear_in(); addr = 11'd9; col_stb = 1; wr_en = 1; wr_bit = 1;
    check("R8 busy", busy, 1);
    mdl[mrow] = mbuf;
    @(negedge clk);
    check("R8 busy 2", busy, 1);
    check("R8 no err", err, 0);
    @(negedge clk); clear_in();
    check("R8 open", row_open, 1);
    check("R8 no err 2", err, 0);
    mbuf = mdl[9]; mrow = 11'd9; mopen = 1;
    col_access(11'd9, 1'b0, 1'b0);
    check("R8 ignored write", rd_bit, 0);

    // R9: row strobe beats column write in the same cycle
    @(negedge clk); clear_in(); addr = 11'd6; row_stb = 1; col_stb = 1; wr_en = 1; wr_bit = 1;
    @(negedge clk); clear_in();
    mdl[mrow] = mbuf;
    repeat (2) @(negedge clk);
    check("R9 opened", row_open, 1);
    mbuf = mdl[6]; mrow = 11'd6; mopen = 1;
    col_access(11'd6, 1'b0, 1'b0);
    check("R9 col write dropped", rd_bit, 0);
    // R9: precharge beats column write
    @(negedge clk); clear_in(); addr = 11'd1; pre_stb = 1; col_stb = 1; wr_en = 1; wr_bit = 1;
    @(negedge clk); clear_in();
    check("R9 precharge wins", row_open, 0);
    check("R9 precharge no err", err, 0);
    mdl[mrow] = mbuf; mopen = 0;
    open_row(11'd6);
    col_access(11'd1, 1'b0, 1'b0);

    // random mix over a few rows
    for (int k = 0; k < 3000; k++) begin
      int op;
      logic [AW-1:0] r;
      op = $urandom % 8;
      case ($urandom % 5)
        0: r = 11'd0;
        1: r = 11'd1;
        2: r = 11'd2;
        3: r = N - 1;
        default: r = AW'($urandom);
      endcase
      case (op)
        0, 1: open_row(r);
        2: precharge();
        3, 4, 5: col_access(AW'($urandom), 1'b0, 1'b0);
        default: col_access(AW'($urandom % 64), 1'b1, 1'($urandom));
      endcase
    end
    done = 1;
    finish_run();
  end
endmodule